// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Control

This block is one eight-pin general-purpose I/O port that a simple synchronous register bus controls. Software sets a data latch and a direction mask. The port turns these into a pad output-enable and a pad output-data value for each pin. Reads of the data address return, for each bit, either the latch or the synchronized pad level. The choice depends on that bit's direction.

A second group of registers is kept apart from the data and direction pair. It holds a pullup request, a slew-rate enable and a drive-strength select for each pin. The slew and drive bits go straight to the pads. The pullup request is qualified before it reaches a pad. Three conditions force it off: the pin is being driven, the pin is assigned to an analog function, or a peripheral owns the pin and drives it.

A peripheral takes ownership of a pin through simple enable, output-enable and data inputs. One pin, bit 2, is fixed as output-only.

Top module: `gpio_pin_port`

## Requirements
- R1: After reset, the data latch and the direction, pullup, slew and drive registers are all zero. Every pad output-enable is therefore 0, except the output-only bit 2.
- R2: When a pin's direction bit is 0 and no peripheral owns the pin, its padOe is 0. Reading the data address (0) returns the synchronized pad level in that bit.
- R3: When a pin's direction bit is 1 and no peripheral owns the pin, padOe is 1 and padDo equals the latch bit. Reading the data address returns the latch bit.
- R4: padPu for a bit is 1 only when all of these hold: the pullup register bit (address 2) is 1, the pad is not being driven, and the pin is not assigned to an analog function.
- R5: padPu is 0 whenever padOe is 1 for that bit, regardless of the pullup register. This includes the case where a peripheral drives the pin.
- R6: padPu is 0 for any bit whose anaSel is 1.
- R7: Bit 2 is output-only. Its padOe is always 1, and data reads return the latch for that bit, whatever its direction bit holds.
- R8: A write changes only the register at the written address. The map is: data 0, direction 1, pullup 2, slew 3, drive 4. Each of these addresses reads back its stored register, except data, which reads as in R2, R3 and R7.
- R9: padSlew and padDrive equal the registers at addresses 3 and 4. Both are updated on the clock edge of the write.
- R10: When perEn is 1 for a bit, padOe and padDo for that bit come from perOe and perDo instead of the direction bit and the latch. The output-only bit 2 keeps padOe at 1 even then.
- R11: Addresses 5 to 7 read as zero, and writes to them change no register.
- R12: A change on padIn appears in the data-address read value after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| padIn | input | 8 | Pad input levels |
| perEn | input | 8 | Peripheral owns the pin |
| perOe | input | 8 | Peripheral output-enable |
| perDo | input | 8 | Peripheral output data |
| anaSel | input | 8 | Pin assigned to an analog function |
| padOe | output | 8 | Pad output-enable |
| padDo | output | 8 | Pad output data |
| padPu | output | 8 | Effective pullup enable |
| padSlew | output | 8 | Slew-rate enable |
| padDrive | output | 8 | Drive-strength select |

## Verification
The bench builds the port with its defaults: eight pins, output-only bit 2 and a two-stage synchronizer. The fixed pin therefore sits between ordinary neighbours on both sides, so a mask error that leaks onto bits 1 or 3 is visible. With two synchronizer stages, the two-edge read latency can be seen directly when pad patterns change every cycle. With a three-bit address, the three unmapped addresses can be reached alongside the five mapped ones.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  localparam int ADDR_DATA  = 0;
  localparam int ADDR_DIR   = 1;
  localparam int ADDR_PULL  = 2;
  localparam int ADDR_SLEW  = 3;
  localparam int ADDR_DRIVE = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PULL,
    SEL_SLEW,
    SEL_DRIVE
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    logic   wrSlew;
    logic   wrDrive;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    case (int'(busAddr))
      ADDR_DATA: begin
        strobe.rdSel  = SEL_DATA;
        strobe.wrData = busWrEn;
      end
      ADDR_DIR: begin
        strobe.rdSel = SEL_DIR;
        strobe.wrDir = busWrEn;
      end
      ADDR_PULL: begin
        strobe.rdSel  = SEL_PULL;
        strobe.wrPull = busWrEn;
      end
      ADDR_SLEW: begin
        strobe.rdSel  = SEL_SLEW;
        strobe.wrSlew = busWrEn;
      end
      ADDR_DRIVE: begin
        strobe.rdSel   = SEL_DRIVE;
        strobe.wrDrive = busWrEn;
      end
      default: ;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrData, strobe.wrDir, strobe.wrPull, strobe.wrSlew, strobe.wrDrive})); // R8

  AST_NO_WRITE_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_NONE) |-> !(strobe.wrData | strobe.wrDir | strobe.wrPull
                                     | strobe.wrSlew | strobe.wrDrive)); // R11

endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp
  import gpio_pin_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int OUT_ONLY_BIT = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] perEn,
  input  logic [WIDTH-1:0] perOe,
  input  logic [WIDTH-1:0] perDo,
  input  logic [WIDTH-1:0] anaSel,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padDo,
  output logic [WIDTH-1:0] padPu,
  output logic [WIDTH-1:0] padSlew,
  output logic [WIDTH-1:0] padDrive
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] latchQ, dirQ, pullQ, slewQ, driveQ;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] dirEff, dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      pullQ  <= '0;
      slewQ  <= '0;
      driveQ <= '0;
    end else begin
      if (strobe.wrData)  latchQ <= busWrData;
      if (strobe.wrDir)   dirQ   <= busWrData;
      if (strobe.wrPull)  pullQ  <= busWrData;
      if (strobe.wrSlew)  slewQ  <= busWrData;
      if (strobe.wrDrive) driveQ <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    if (b == OUT_ONLY_BIT) begin : g_outOnly
      assign dirEff[b] = 1'b1;
      assign padOe[b]  = 1'b1;
    end else begin : g_bidir
      assign dirEff[b] = dirQ[b];
      assign padOe[b]  = perEn[b] ? perOe[b] : dirQ[b];
    end
    assign padDo[b]    = perEn[b] ? perDo[b] : latchQ[b];
    assign padPu[b]    = pullQ[b] & ~padOe[b] & ~anaSel[b];
    assign dataView[b] = dirEff[b] ? latchQ[b] : syncQ[LAST_STAGE][b];
  end

  assign padSlew  = slewQ;
  assign padDrive = driveQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_DATA:  busRdData = dataView;
      SEL_DIR:   busRdData = dirQ;
      SEL_PULL:  busRdData = pullQ;
      SEL_SLEW:  busRdData = slewQ;
      SEL_DRIVE: busRdData = driveQ;
      default:   busRdData = '0;
    endcase
  end

  AST_PU_OFF_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (padPu & padOe) == '0); // R5

  AST_PU_OFF_ANALOG: assert property (@(posedge clk) disable iff (!rstN)
    (padPu & anaSel) == '0); // R6

  AST_DIR_RESET: assert property (@(posedge clk)
    !rstN |=> (dirQ == '0)); // R1

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirQ)); // R8

  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrPull |=> $stable(pullQ)); // R8

  AST_OUT_ONLY_OE: assert property (@(posedge clk) disable iff (!rstN)
    padOe[OUT_ONLY_BIT]); // R7

endmodule

// File: rtl/gpio_pin_port.sv
module gpio_pin_port
  import gpio_pin_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int ADDR_W       = 3,
  parameter int OUT_ONLY_BIT = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  perEn,
  input  logic [WIDTH-1:0]  perOe,
  input  logic [WIDTH-1:0]  perDo,
  input  logic [WIDTH-1:0]  anaSel,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padDo,
  output logic [WIDTH-1:0]  padPu,
  output logic [WIDTH-1:0]  padSlew,
  output logic [WIDTH-1:0]  padDrive
);

  ctlStrobe_t strobe;

  gpio_pin_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_pin_dp #(
    .WIDTH        (WIDTH),
    .OUT_ONLY_BIT (OUT_ONLY_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .perEn     (perEn),
    .perOe     (perOe),
    .perDo     (perDo),
    .anaSel    (anaSel),
    .padOe     (padOe),
    .padDo     (padDo),
    .padPu     (padPu),
    .padSlew   (padSlew),
    .padDrive  (padDrive)
  );

endmodule

// File: tb/gpio_pin_port_tb.sv
`timescale 1ns/1ps
module gpio_pin_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0, padIn = '0, perEn = '0, perOe = '0, perDo = '0, anaSel = '0;
  logic [7:0] busRdData, padOe, padDo, padPu, padSlew, padDrive;

  always #2 clk = ~clk;

  gpio_pin_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .perEn(perEn), .perOe(perOe), .perDo(perDo), .anaSel(anaSel),
    .padOe(padOe), .padDo(padDo), .padPu(padPu), .padSlew(padSlew),
    .padDrive(padDrive)
  );

  // behavioural reference state
  logic [7:0] mLat, mDir, mPull, mSlew, mDrv;
  logic [7:0] padHist [$];
  int vectors = 0, fails = 0;
  string tag = "R1";

  function automatic logic [7:0] padDelayed();
    // value of padIn as it stood two rising edges ago (zero before that)
    if (padHist.size() < 2) return 8'h00;
    return padHist[padHist.size()-2];
  endfunction

  task automatic checkVal(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eOe, eDo, ePu, eRd, synced;
    synced = padDelayed();
    for (int b = 0; b < 8; b++) begin
      if (b == 2)        eOe[b] = 1'b1;
      else if (perEn[b]) eOe[b] = perOe[b];
      else               eOe[b] = mDir[b];
      eDo[b] = perEn[b] ? perDo[b] : mLat[b];
      ePu[b] = mPull[b] && !eOe[b] && !anaSel[b];
    end
    case (busAddr)
      3'd0: for (int b = 0; b < 8; b++) eRd[b] = (b == 2 || mDir[b]) ? mLat[b] : synced[b];
      3'd1: eRd = mDir;
      3'd2: eRd = mPull;
      3'd3: eRd = mSlew;
      3'd4: eRd = mDrv;
      default: eRd = 8'h00;
    endcase
    checkVal("padOe", padOe, eOe);
    checkVal("padDo", padDo, eDo);
    checkVal("padPu", padPu, ePu);
    checkVal("padSlew", padSlew, mSlew);
    checkVal("padDrive", padDrive, mDrv);
    checkVal("busRdData", busRdData, eRd);
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic cycle();
    #1;
    compareAll();
    @(posedge clk);
    if (!rstN) begin
      mLat = 0; mDir = 0; mPull = 0; mSlew = 0; mDrv = 0;
      padHist.delete();
    end else begin
      if (busWrEn) case (busAddr)
        3'd0: mLat = busWrData;
        3'd1: mDir = busWrData;
        3'd2: mPull = busWrData;
        3'd3: mSlew = busWrData;
        3'd4: mDrv = busWrData;
        default: ;
      endcase
    end
    padHist.push_back(rstN ? padIn : 8'h00);
    if (padHist.size() > 4) void'(padHist.pop_front());
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    cycle();
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a);
    busAddr = a; busWrEn = 1'b0;
    cycle();
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    mLat = 0; mDir = 0; mPull = 0; mSlew = 0; mDrv = 0;
    @(negedge clk);
    tag = "R1";
    padIn = 8'hA5;
    for (int i = 0; i < 3; i++) cycle();
    rstN = 1'b1;
    for (int a = 0; a < 5; a++) rd(3'(a));

    tag = "R12";
    busAddr = 3'd0;
    padIn = 8'h3C; cycle(); cycle(); cycle();
    padIn = 8'hC3; cycle(); padIn = 8'h5A; cycle(); cycle(); cycle();

    tag = "R2";
    for (int i = 0; i < 6; i++) begin padIn = 8'h11 << (i % 4); rd(3'd0); end

    tag = "R3";
    wr(3'd0, 8'h96); wr(3'd1, 8'hF0);
    padIn = 8'h0F; rd(3'd0); rd(3'd0); rd(3'd0);

    tag = "R7";
    wr(3'd1, 8'h00); rd(3'd0); rd(3'd0); wr(3'd1, 8'hFB); rd(3'd0);

    tag = "R4";
    wr(3'd1, 8'h0F); wr(3'd2, 8'hFF); rd(3'd2); rd(3'd0);

    tag = "R5";
    perEn = 8'hF0; perOe = 8'h30; perDo = 8'hA0; rd(3'd0); rd(3'd2);

    tag = "R10";
    perEn = 8'hFF; perOe = 8'h55; perDo = 8'h3C; rd(3'd0); perOe = 8'h00; rd(3'd1);
    perEn = 8'h00;

    tag = "R6";
    wr(3'd1, 8'h00); anaSel = 8'h81; rd(3'd2); anaSel = 8'hFF; rd(3'd2); anaSel = 8'h00;

    tag = "R9";
    wr(3'd3, 8'h5A); wr(3'd4, 8'hC6); rd(3'd3); rd(3'd4);

    tag = "R11";
    wr(3'd5, 8'hFF); wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
    for (int a = 0; a < 8; a++) rd(3'(a));

    tag = "R8";
    for (int i = 0; i < 2000; i++) begin
      busAddr = 3'($urandom_range(0, 7));
      busWrEn = 1'($urandom_range(0, 1));
      busWrData = 8'($urandom);
      padIn = 8'($urandom);
      perEn = 8'($urandom) & 8'($urandom);
      perOe = 8'($urandom);
      perDo = 8'($urandom);
      anaSel = 8'($urandom) & 8'($urandom);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule